// File: doc/BRIEF.md
# Bus-Master DMA Register Decoder

This block is the register front end for the bus-master I/O window of a two-channel IDE controller. The window holds eight bytes per channel. The first four bytes are the command, shared interrupt-mode, status and transfer-timing registers. The next four bytes are the channel's descriptor-table pointer. The block takes I/O accesses made of a valid strobe, a read/write flag, an address, a size code and data. It returns read data and applies each register's own per-bit write rules.

The DMA engine drives the status flags through event inputs. The engine receives the start and direction bits from the command register, and the descriptor pointer. The interrupt logic owns the pending bits of the shared mode byte and feeds them in. It receives back the two per-channel block (mask) bits and an update pulse. On that pulse it resyncs its pending state and recomputes the interrupt output.

Top module: `busmaster_reg_decode`

## Requirements
- R1: After reset, every register reads zero, and `dma_start`, `dma_dir`, `irq_block`, `desc_ptr` and `mode_upd` are zero.
- R2: Only size code 0 (one byte) is honoured. A read with size code 1 returns 0x0000FFFF. A read with size code 2 or 3 returns 0xFFFFFFFF. A write with any size other than 0 changes nothing.
- R3: Address bit 3 selects the channel. With bit 2 low, bits 1:0 select command (0), mode (1), status (2) or timing (3). With bit 2 high, bits 1:0 select a pointer byte, least significant byte first. Byte reads return the selected byte in bits 7:0, with the upper bits zero.
- R4: Command bits 0 and 3 are stored, and the other command bits read zero. Bit 0 drives `dma_start` and bit 3 drives `dma_dir` for that channel.
- R5: A status write loads bits 5 and 6 from the data. Status bits 3, 4 and 7 always read zero.
- R6: Status bit 0 is read-only. It shows the channel's `evt_active` input as sampled at the previous clock edge.
- R7: Status bits 1 (error) and 2 (interrupt) are set by one-cycle pulses on `evt_error` and `evt_irq`. A status write clears each of them where the data bit is 1 and leaves it alone where the data bit is 0. A set event in the same cycle as a clearing write wins.
- R8: A byte write to offset 1 of either channel changes only mode bits 5:4, which drive `irq_block[1:0]`. A mode read returns {2'b00, irq_block, irq_pend, 2'b00}.
- R9: `mode_upd` is high for exactly the one cycle after each accepted mode write.
- R10: Each channel's timing byte is writable in all eight bits, independently of the other channel.
- R11: Each pointer byte is writable on its own, and the 32-bit pointer appears on `desc_ptr`, with channel 0 in the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | Access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 4 | Byte address inside the 16-byte window |
| io_size | input | 2 | 0 = byte, 1 = two bytes, 2/3 = four bytes |
| io_wdata | input | 32 | Write data, byte in bits 7:0 |
| io_rdata | output | 32 | Read data |
| evt_active | input | 2 | Per-channel engine active level |
| evt_error | input | 2 | Per-channel error set pulse |
| evt_irq | input | 2 | Per-channel interrupt set pulse |
| irq_pend | input | 2 | Interrupt pending bits from the interrupt logic |
| dma_start | output | 2 | Per-channel start bit |
| dma_dir | output | 2 | Per-channel direction bit |
| irq_block | output | 2 | Per-channel interrupt block bits |
| mode_upd | output | 1 | One-cycle pulse after a mode write |
| desc_ptr | output | 64 | Descriptor pointers, channel 0 low |

## Verification
Reads are combinational, so read data is due in the same cycle the address is applied. The bench samples it 1 ns after driving, on the falling half of the clock. Writes and event pulses land at the next rising edge, so their effects on registers, status bits and output ports are due one edge later. The bench checks them at the following falling edge. `mode_upd` and the `evt_active` copy in status each carry exactly one register stage, and the bench samples them at that same falling edge.

// File: rtl/bmreg_pkg.sv
// Package: shared offsets, size codes and status bit positions for the
// bus-master register decoder. Assumes a byte-addressed 8-byte window per channel.
package bmreg_pkg;
    localparam int NCH     = 2;
    localparam int WIN_AW  = 3;             // address bits inside one channel window
    localparam int PTR_W   = 32;
    localparam int PTR_NB  = PTR_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_MODE = 2'd1;
    localparam logic [1:0] OFF_STAT = 2'd2;
    localparam logic [1:0] OFF_TIM  = 2'd3;

    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_IRQ = 2;
    localparam logic [7:0] ST_PLAIN_MASK = 8'h60;
    localparam logic [7:0] CMD_MASK      = 8'h09;
    localparam logic [7:0] MODE_WR_MASK  = 8'h30;
endpackage

// File: rtl/bm_chan_regs.sv
// Module: one channel's private registers (command, status, timing, pointer).
// Assumes the parent has already qualified wr_en with a byte-sized write to
// this channel. All state resets synchronously to zero.
module bm_chan_regs
    import bmreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_off,
    input  logic [7:0]        wdata,
    input  logic              evt_active,
    input  logic              evt_error,
    input  logic              evt_irq,
    output logic [7:0]        cmd_q,
    output logic [7:0]        stat_q,
    output logic [7:0]        tim_q,
    output logic [PTR_W-1:0]  ptr_q
);
    logic wr_cmd, wr_stat, wr_tim;
    assign wr_cmd  = wr_en && !wr_off[2] && wr_off[1:0] == OFF_CMD;
    assign wr_stat = wr_en && !wr_off[2] && wr_off[1:0] == OFF_STAT;
    assign wr_tim  = wr_en && !wr_off[2] && wr_off[1:0] == OFF_TIM;

    // Command register: only start and direction bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (wr_cmd) cmd_q <= wdata & CMD_MASK;
    end

    // Status register: plain bits, a sampled active bit, and sticky set/W1C flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q[ST_ACT] <= evt_active;
            if (wr_stat) stat_q[6:5] <= wdata[6:5];
            stat_q[ST_ERR] <= evt_error || (stat_q[ST_ERR] && !(wr_stat && wdata[ST_ERR]));
            stat_q[ST_IRQ] <= evt_irq   || (stat_q[ST_IRQ] && !(wr_stat && wdata[ST_IRQ]));
        end
    end

    // Timing register: every bit writable.
    always_ff @(posedge clk) begin
        if (!rst_n)      tim_q <= '0;
        else if (wr_tim) tim_q <= wdata;
    end

    // Pointer bytes: one byte lane per generate step.
    for (genvar b = 0; b < PTR_NB; b++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)                                   ptr_q[b*8 +: 8] <= '0;
            else if (wr_en && wr_off[2] && wr_off[1:0] == b[1:0]) ptr_q[b*8 +: 8] <= wdata;
        end
    end

    assert_w1c_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[ST_ERR] && !evt_error) |=> !stat_q[ST_ERR]);
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> stat_q[ST_IRQ]);
    assert_active_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stat_q[ST_ACT] == $past(evt_active));
    assert_tim_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tim |=> tim_q == $past(wdata));
    assert_stat_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[7] == 1'b0 && stat_q[4:3] == 2'b00);
endmodule

// File: rtl/bm_mode_reg.sv
// Module: shared interrupt-mode byte. It holds only the per-channel block bits.
// The pending bits live in the interrupt logic and are merged on read.
// It also emits a one-cycle update pulse after each write.
module bm_mode_reg
    import bmreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wdata,
    input  logic [NCH-1:0]  pend,
    output logic [NCH-1:0]  blk_q,
    output logic            upd_q,
    output logic [7:0]      rd_byte
);
    // Block bits: only the masked field is written.
    always_ff @(posedge clk) begin
        if (!rst_n)     blk_q <= '0;
        else if (wr_en) blk_q <= wdata[5:4];
    end

    // Update pulse for the interrupt resync.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wr_en;
    end

    assign rd_byte = {2'b00, blk_q, pend, 2'b00};

    assert_blk_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> blk_q == $past(wdata[5:4]));
    assert_upd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && !$past(wr_en, 1)) |-> 1'b0);
endmodule

// File: rtl/busmaster_reg_decode.sv
// Module: top of the bus-master window decoder. It qualifies accesses by size,
// routes byte writes to the channel or mode registers, and builds read data
// combinationally from registered state.
module busmaster_reg_decode
    import bmreg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_valid,
    input  logic                  io_write,
    input  logic [3:0]            io_addr,
    input  logic [1:0]            io_size,
    input  logic [31:0]           io_wdata,
    output logic [31:0]           io_rdata,
    input  logic [NCH-1:0]        evt_active,
    input  logic [NCH-1:0]        evt_error,
    input  logic [NCH-1:0]        evt_irq,
    input  logic [NCH-1:0]        irq_pend,
    output logic [NCH-1:0]        dma_start,
    output logic [NCH-1:0]        dma_dir,
    output logic [NCH-1:0]        irq_block,
    output logic                  mode_upd,
    output logic [NCH*PTR_W-1:0]  desc_ptr
);
    logic            byte_wr;
    logic            sel_ch;
    logic [2:0]      off;
    logic            mode_wr;
    logic [7:0]      mode_rd;
    logic [7:0]      cmd_v [NCH];
    logic [7:0]      stat_v[NCH];
    logic [7:0]      tim_v [NCH];
    logic [PTR_W-1:0] ptr_v[NCH];

    assign byte_wr = io_valid && io_write && io_size == SZ_BYTE;
    assign sel_ch  = io_addr[WIN_AW];
    assign off     = io_addr[WIN_AW-1:0];
    assign mode_wr = byte_wr && !off[2] && off[1:0] == OFF_MODE;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bm_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (byte_wr && sel_ch == c[0]),
            .wr_off     (off),
            .wdata      (io_wdata[7:0]),
            .evt_active (evt_active[c]),
            .evt_error  (evt_error[c]),
            .evt_irq    (evt_irq[c]),
            .cmd_q      (cmd_v[c]),
            .stat_q     (stat_v[c]),
            .tim_q      (tim_v[c]),
            .ptr_q      (ptr_v[c])
        );
        assign dma_start[c]              = cmd_v[c][0];
        assign dma_dir[c]                = cmd_v[c][3];
        assign desc_ptr[c*PTR_W +: PTR_W] = ptr_v[c];
    end

    bm_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wdata   (io_wdata[7:0]),
        .pend    (irq_pend),
        .blk_q   (irq_block),
        .upd_q   (mode_upd),
        .rd_byte (mode_rd)
    );

    // Read mux: size check first, then register or pointer byte select.
    always_comb begin
        logic [7:0] rb;
        rb = '0;
        if (off[2]) begin
            rb = ptr_v[sel_ch][off[1:0]*8 +: 8];
        end else begin
            unique case (off[1:0])
                OFF_CMD:  rb = cmd_v[sel_ch];
                OFF_MODE: rb = mode_rd;
                OFF_STAT: rb = stat_v[sel_ch];
                default:  rb = tim_v[sel_ch];
            endcase
        end
        if (io_size == SZ_BYTE)      io_rdata = {24'h0, rb};
        else if (io_size == SZ_HALF) io_rdata = 32'h0000_FFFF;
        else                         io_rdata = 32'hFFFF_FFFF;
    end

    assert_wide_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_size != SZ_BYTE) |=>
        $stable(dma_start) && $stable(dma_dir) && $stable(irq_block) && $stable(desc_ptr));
    assert_wide_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_size != SZ_BYTE) |-> io_rdata[15:0] == 16'hFFFF);
endmodule

// File: tb/test_busmaster_reg_decode.sv
// Bench: sweeps byte values through every register of both channels and
// compares against expected values computed from the requirements.
module test_busmaster_reg_decode;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_valid = 0, io_write = 0;
    logic [3:0]  io_addr = 0;
    logic [1:0]  io_size = 0;
    logic [31:0] io_wdata = 0;
    logic [31:0] io_rdata;
    logic [1:0]  evt_active = 0, evt_error = 0, evt_irq = 0, irq_pend = 0;
    logic [1:0]  dma_start, dma_dir, irq_block;
    logic        mode_upd;
    logic [63:0] desc_ptr;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    busmaster_reg_decode i_busmaster_reg_decode (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .evt_active(evt_active), .evt_error(evt_error), .evt_irq(evt_irq),
        .irq_pend(irq_pend), .dma_start(dma_start), .dma_dir(dma_dir),
        .irq_block(irq_block), .mode_upd(mode_upd), .desc_ptr(desc_ptr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a write at a falling edge; return at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        io_valid = 1; io_write = 1; io_addr = a; io_size = s; io_wdata = d;
        @(negedge clk);
        io_valid = 0; io_write = 0;
    endtask

    // Combinational read, sampled 1 ns after driving.
    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] q);
        io_valid = 1; io_write = 0; io_addr = a; io_size = s;
        #1 q = io_rdata;
        io_valid = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state at every byte offset and on all ports.
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], 2'd0, q);
            chk("R1 reset read", q, 0);
        end
        chk("R1 reset ports", {dma_start, dma_dir, irq_block, mode_upd}, 0);
        chk("R1 reset ptr", desc_ptr, 0);

        // R2: wide reads return all ones of their width.
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], 2'd1, q); chk("R2 half read", q, 32'h0000FFFF);
            rd(a[3:0], 2'd2, q); chk("R2 word read", q, 32'hFFFFFFFF);
            rd(a[3:0], 2'd3, q); chk("R2 size3 read", q, 32'hFFFFFFFF);
        end
        // R2: wide writes are ignored at every offset.
        for (int a = 0; a < 16; a++) begin
            wr(a[3:0], 2'd1, 32'hFFFFFFFF);
            wr(a[3:0], 2'd2, 32'hFFFFFFFF);
        end
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], 2'd0, q);
            chk("R2 wide write ignored", q, 0);
        end
        chk("R2 ports after wide writes", {dma_start, dma_dir, irq_block, desc_ptr}, 0);

        // R3 R4: command sweep on both channels.
        for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 256; d++) begin
                wr({c[0], 3'd0}, 2'd0, d);
                rd({c[0], 3'd0}, 2'd0, q);
                chk("R4 cmd readback", q, d & 8'h09);
                chk("R4 start port", dma_start[c], d[0]);
                chk("R4 dir port", dma_dir[c], d[3]);
            end
            wr({c[0], 3'd0}, 2'd0, 0);
        end

        // R8 R9: mode sweep through both channel aliases.
        for (int d = 0; d < 256; d++) begin
            irq_pend = d[7:6];
            wr({d[0], 3'd1}, 2'd0, d);
            chk("R9 upd pulse high", mode_upd, 1);
            rd({~d[0], 3'd1}, 2'd0, q);
            chk("R8 mode readback", q, {2'b00, d[5:4], d[7:6], 2'b00});
            chk("R8 block port", irq_block, d[5:4]);
            @(negedge clk);
            chk("R9 upd pulse one cycle", mode_upd, 0);
        end
        irq_pend = 0;
        wr(4'd1, 2'd0, 0);

        // R10 R3: timing sweep, each channel's byte is independent.
        for (int d = 0; d < 256; d++) begin
            wr(4'd3, 2'd0, d);
            wr(4'd11, 2'd0, 255 - d);
            rd(4'd3, 2'd0, q);  chk("R10 timing ch0", q, d);
            rd(4'd11, 2'd0, q); chk("R10 timing ch1", q, 255 - d);
        end

        // R11 R3: pointer bytes, least significant first.
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 4; b++)
                wr({c[0], 1'b1, b[1:0]}, 2'd0, 8'h10 * (c * 4 + b + 1) + b);
        chk("R11 ptr port", desc_ptr, 64'h83726150_43322110);
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 4; b++) begin
                rd({c[0], 1'b1, b[1:0]}, 2'd0, q);
                chk("R11 ptr byte read", q, 8'h10 * (c * 4 + b + 1) + b);
            end

        // R5 R6 R7: status sweep, both flags set beforehand by events.
        for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 256; d++) begin
                @(negedge clk);
                evt_active[c] = d[3]; evt_error[c] = 1; evt_irq[c] = 1;
                @(negedge clk);
                evt_error[c] = 0; evt_irq[c] = 0;
                wr({c[0], 3'd2}, 2'd0, d);
                e = (d[7:0] & 8'h60) | {7'b0, d[3]} | (~d[7:0] & 8'h06);
                rd({c[0], 3'd2}, 2'd0, q);
                chk("R5 R6 R7 status", q, e);
            end
            wr({c[0], 3'd2}, 2'd0, 8'h06);
            evt_active[c] = 0;
        end

        // R7: set event beats a clearing write in the same cycle.
        @(negedge clk);
        io_valid = 1; io_write = 1; io_addr = 4'd2; io_size = 0; io_wdata = 32'h06;
        evt_error[0] = 1; evt_irq[0] = 1;
        @(negedge clk);
        io_valid = 0; io_write = 0; evt_error[0] = 0; evt_irq[0] = 0;
        rd(4'd2, 2'd0, q);
        chk("R7 set wins", q, 8'h06);
        // R6: active bit tracks the input with one edge of delay; write cannot set it.
        wr(4'd2, 2'd0, 8'h01);
        rd(4'd2, 2'd0, q);
        chk("R6 active read-only", q[0], 0);
        evt_active[0] = 1;
        #1 rd(4'd2, 2'd0, q);
        chk("R6 active before edge", q[0], 0);
        @(negedge clk);
        rd(4'd2, 2'd0, q);
        chk("R6 active after edge", q[0], 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule